// File: doc/BRIEF.md
# Power Domain Request Handshake Controller

This block sequences a single power-up or power-down of one of ten non-processor power domains. A caller pulses a request together with an on/off flag and a 12-bit domain register offset. The controller maps the offset to a domain number and a status-bit position. It then raises exactly one command bit towards a power manager and holds an enable flag high while the operation runs.

While the operation runs, the controller polls at a fixed interval. Each poll checks the manager's acknowledge vector and two copies of the power-status vector. The operation succeeds when the acknowledge shows the posted command bit and both status copies report the requested state. The operation fails once the attempt budget runs out. Either outcome clears the command bit, drops the enable flag and produces a one-cycle done pulse with a result flag. The result flag then holds until the next accepted request. An offset outside the table is rejected at once and nothing is posted.

Top module: `pwr_hs_ctrl`

## Requirements
- R1: After synchronous reset, `cmd_o` is zero and `en_o`, `done_o` and `err_o` are all low.
- R2: Offsets map to a domain and a status bit as follows: 0x210→0/7, 0x230→1/21, 0x238→2/5, 0x23c→3/3, 0x298→4/20, 0x29c→5/24, 0x2c4→6/23, 0x2c0→7/22, 0x214→8/4, 0x2cc→9/25. An accepted request sets `cmd_o` one-hot on the next cycle. The bit is the domain number for power-on (`req_on_i`=1) and the domain number plus 10 for power-off.
- R3: `en_o` rises together with the command bit and stays high until the cycle in which `done_o` is high. In that cycle `en_o` is low, whatever the result.
- R4: A poll succeeds only when three conditions hold together: `ack_i & cmd_o` is nonzero, `pwr_sta_i` at the mapped bit equals `req_on_i`, and `pwr_sta2_i` at the mapped bit equals `req_on_i`. On success, `done_o` pulses with `err_o`=0.
- R5: `cmd_o` returns to zero in the cycle `done_o` is high, on both success and timeout.
- R6: The first poll samples the inputs at the first clock edge after acceptance. Later polls come every `POLL_INTERVAL` cycles. A condition that becomes true between polls is seen only at the next poll.
- R7: After `MAX_POLLS`+1 failed polls, `done_o` pulses with `err_o`=1. This is visible after the edge 1+`MAX_POLLS`·`POLL_INTERVAL` cycles after the accepting edge.
- R8: A request with an unmapped offset gives `done_o`=1 and `err_o`=1 on the next cycle. `cmd_o` stays zero and `en_o` stays low.
- R9: A request strobe that arrives while an operation is running is ignored. `cmd_o` is unchanged, and the running operation completes on its own terms.
- R10: `done_o` is high for exactly one cycle per operation. `err_o` holds its value after the pulse and is cleared when the next valid request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe |
| req_on_i | input | 1 | 1 = power on, 0 = power off |
| req_ofs_i | input | 12 | Domain register offset |
| ack_i | input | 20 | Acknowledge vector from the power manager |
| pwr_sta_i | input | 32 | Primary power-status vector |
| pwr_sta2_i | input | 32 | Secondary power-status vector |
| cmd_o | output | 20 | One-hot command vector to the power manager |
| en_o | output | 1 | Operation-in-progress enable flag |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Result: 1 = error (timeout or unmapped offset) |

## Verification
The command bit and `en_o` appear one cycle after the accepting edge. An unmapped offset produces its done pulse in that same cycle. Success is reported one cycle after the poll edge that first sees all three conditions. Polls fall at edges 1, 1+P, 1+2P and so on after acceptance, so a timeout lands exactly 1+MAX_POLLS·P edges after acceptance. The bench drives inputs and samples outputs on falling edges, counting rising edges from the accepting one. It checks `done_o` low on the edge before each due cycle and high on the due cycle itself.

// File: rtl/pwr_hs_pkg.sv
package pwr_hs_pkg;

    localparam int N_DOM = 10;
    localparam int CMD_W = 2 * N_DOM;
    localparam int STA_W = 32;
    localparam int OFS_W = 12;
    localparam int DOM_W = $clog2(N_DOM);
    localparam int STB_W = $clog2(STA_W);

    typedef struct packed {
        logic             hit;
        logic [DOM_W-1:0] dom;
        logic [STB_W-1:0] stbit;
    } dom_map_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } hs_state_t;

    function automatic dom_map_t map_offset(input logic [OFS_W-1:0] ofs);
        dom_map_t m;
        m = '0;
        m.hit = 1'b1;
        case (ofs)
            12'h210: begin m.dom = DOM_W'(0); m.stbit = STB_W'(7);  end
            12'h230: begin m.dom = DOM_W'(1); m.stbit = STB_W'(21); end
            12'h238: begin m.dom = DOM_W'(2); m.stbit = STB_W'(5);  end
            12'h23c: begin m.dom = DOM_W'(3); m.stbit = STB_W'(3);  end
            12'h298: begin m.dom = DOM_W'(4); m.stbit = STB_W'(20); end
            12'h29c: begin m.dom = DOM_W'(5); m.stbit = STB_W'(24); end
            12'h2c4: begin m.dom = DOM_W'(6); m.stbit = STB_W'(23); end
            12'h2c0: begin m.dom = DOM_W'(7); m.stbit = STB_W'(22); end
            12'h214: begin m.dom = DOM_W'(8); m.stbit = STB_W'(4);  end
            12'h2cc: begin m.dom = DOM_W'(9); m.stbit = STB_W'(25); end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pwr_hs_decode.sv
module pwr_hs_decode
    import pwr_hs_pkg::*;
(
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             on_i,
    output logic             hit_o,
    output logic [STB_W-1:0] stbit_o,
    output logic [CMD_W-1:0] cmd_o
);
    localparam int SEL_W = $clog2(CMD_W);

    dom_map_t         map;
    logic [SEL_W-1:0] sel;

    always_comb begin
        map     = map_offset(ofs_i);
        hit_o   = map.hit;
        stbit_o = map.stbit;
        sel     = on_i ? SEL_W'(map.dom) : SEL_W'(map.dom) + SEL_W'(N_DOM);
    end

    for (genvar g = 0; g < CMD_W; g++) begin : g_cmd
        assign cmd_o[g] = hit_o && (sel == SEL_W'(g));
    end
endmodule

// File: rtl/pwr_hs_poll_timer.sv
module pwr_hs_poll_timer #(
    parameter int POLL_INTERVAL = 2000,
    parameter int MAX_POLLS     = 10000,
    parameter int CNT_W         = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic run_i,
    input  logic fail_i,
    output logic tick_o,
    output logic exhausted_o
);
    localparam int PS_W = $clog2(POLL_INTERVAL + 1);

    logic [PS_W-1:0]  presc;
    logic [CNT_W-1:0] tries;

    assign tick_o      = run_i && (presc == '0);
    assign exhausted_o = (tries == CNT_W'(MAX_POLLS));

    always_ff @(posedge clk) begin
        if (rst || start_i || !run_i) begin
            presc <= '0;
        end else if (presc == PS_W'(POLL_INTERVAL - 1)) begin
            presc <= '0;
        end else begin
            presc <= presc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            tries <= '0;
        end else if (tick_o && fail_i && !exhausted_o) begin
            tries <= tries + 1'b1;
        end
    end

    AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (rst)
        presc < PS_W'(POLL_INTERVAL)); // R6
    AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (rst)
        tries <= CNT_W'(MAX_POLLS)); // R7
endmodule

// File: rtl/pwr_hs_ctrl.sv
module pwr_hs_ctrl
    import pwr_hs_pkg::*;
#(
    parameter int POLL_INTERVAL = 2000,
    parameter int MAX_POLLS     = 10000,
    parameter int CNT_W         = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid_i,
    input  logic             req_on_i,
    input  logic [11:0]      req_ofs_i,
    input  logic [19:0]      ack_i,
    input  logic [31:0]      pwr_sta_i,
    input  logic [31:0]      pwr_sta2_i,
    output logic [19:0]      cmd_o,
    output logic             en_o,
    output logic             done_o,
    output logic             err_o
);
    hs_state_t        state;
    logic             on_q;
    logic [STB_W-1:0] stbit_q;
    logic             dec_hit;
    logic [STB_W-1:0] dec_stbit;
    logic [CMD_W-1:0] dec_cmd;
    logic             start, match, tick, exhausted;

    pwr_hs_decode u_dec (
        .ofs_i   (req_ofs_i),
        .on_i    (req_on_i),
        .hit_o   (dec_hit),
        .stbit_o (dec_stbit),
        .cmd_o   (dec_cmd)
    );

    assign start = (state == ST_IDLE) && req_valid_i && dec_hit;
    assign match = (|(ack_i & cmd_o))
                && (pwr_sta_i[stbit_q]  == on_q)
                && (pwr_sta2_i[stbit_q] == on_q);

    pwr_hs_poll_timer #(
        .POLL_INTERVAL (POLL_INTERVAL),
        .MAX_POLLS     (MAX_POLLS),
        .CNT_W         (CNT_W)
    ) u_tmr (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .run_i       (state == ST_WAIT),
        .fail_i      (!match),
        .tick_o      (tick),
        .exhausted_o (exhausted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cmd_o   <= '0;
            en_o    <= 1'b0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            on_q    <= 1'b0;
            stbit_q <= '0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid_i) begin
                        if (dec_hit) begin
                            cmd_o   <= dec_cmd;
                            en_o    <= 1'b1;
                            on_q    <= req_on_i;
                            stbit_q <= dec_stbit;
                            err_o   <= 1'b0;
                            state   <= ST_WAIT;
                        end else begin
                            done_o <= 1'b1;
                            err_o  <= 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (tick && (match || exhausted)) begin
                        done_o <= 1'b1;
                        err_o  <= !match;
                        cmd_o  <= '0;
                        en_o   <= 1'b0;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_o)); // R2
    AST_EN_HAS_CMD: assert property (@(posedge clk) disable iff (rst)
        en_o |-> ($countones(cmd_o) == 1)); // R3
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!en_o && (cmd_o == '0))); // R5
    AST_OK_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o) |-> ($past(ack_i & cmd_o) != '0)); // R4
    AST_BUSY_HOLDS_CMD: assert property (@(posedge clk) disable iff (rst)
        (en_o && $past(en_o)) |-> $stable(cmd_o)); // R9
endmodule

// File: tb/pwr_hs_ctrl_tb.sv
module pwr_hs_ctrl_tb;
    localparam int P = 4;
    localparam int M = 5;
    localparam int NV = 13;
    // entry: {offset[11:0], valid[3:0], domain[3:0], status bit[7:0]}
    localparam logic [27:0] TBL [NV] = '{
        28'h210_1_0_07, 28'h230_1_1_15, 28'h238_1_2_05, 28'h23c_1_3_03,
        28'h298_1_4_14, 28'h29c_1_5_18, 28'h2c4_1_6_17, 28'h2c0_1_7_16,
        28'h214_1_8_04, 28'h2cc_1_9_19, 28'h000_0_0_00, 28'h2c8_0_0_00,
        28'h211_0_0_00
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0, req_on_i = 1'b0;
    logic [11:0] req_ofs_i = '0;
    logic [19:0] ack_i = '0;
    logic [31:0] pwr_sta_i = '0, pwr_sta2_i = '0;
    logic [19:0] cmd_o;
    logic        en_o, done_o, err_o;
    int          n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    pwr_hs_ctrl #(.POLL_INTERVAL(P), .MAX_POLLS(M), .CNT_W(14)) u_dut (
        .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_on_i(req_on_i),
        .req_ofs_i(req_ofs_i), .ack_i(ack_i), .pwr_sta_i(pwr_sta_i),
        .pwr_sta2_i(pwr_sta2_i), .cmd_o(cmd_o), .en_o(en_o),
        .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic request(input logic on, input logic [11:0] ofs);
        req_valid_i = 1'b1; req_on_i = on; req_ofs_i = ofs;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic satisfy(input logic on, input int bitn, input int st);
        ack_i      = 20'(1) << bitn;
        pwr_sta_i  = on ? (32'h1 << st) : ~(32'h1 << st);
        pwr_sta2_i = pwr_sta_i;
    endtask

    task automatic idle_inputs();
        ack_i = '0; pwr_sta_i = '0; pwr_sta2_i = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd", 32'(cmd_o), 0);
        chk("R1 en", 32'(en_o), 0);
        chk("R1 done", 32'(done_o), 0);
        chk("R1 err", 32'(err_o), 0);

        // Table walk: R2 decode, R4 success, R5 clear, R3 enable, R8 invalid
        for (int i = 0; i < NV; i++) begin
            for (int on = 1; on >= 0; on--) begin
                automatic logic [11:0] ofs = TBL[i][27:16];
                automatic bit          vld = TBL[i][12];
                automatic int          dom = int'(TBL[i][11:8]);
                automatic int          st  = int'(TBL[i][7:0]);
                automatic int          bitn = on ? dom : dom + 10;
                idle_inputs();
                request(on[0], ofs);
                if (vld) begin
                    chk("R2 cmd bit", 32'(cmd_o), 32'(20'(1) << bitn));
                    chk("R3 en high", 32'(en_o), 1);
                    satisfy(on[0], bitn, st);
                    @(negedge clk);
                    chk("R4 done", 32'(done_o), 1);
                    chk("R4 err", 32'(err_o), 0);
                    chk("R5 cmd clear", 32'(cmd_o), 0);
                    chk("R3 en low", 32'(en_o), 0);
                end else begin
                    chk("R8 done", 32'(done_o), 1);
                    chk("R8 err", 32'(err_o), 1);
                    chk("R8 cmd", 32'(cmd_o), 0);
                    chk("R8 en", 32'(en_o), 0);
                end
                @(negedge clk);
                chk("R10 pulse", 32'(done_o), 0);
            end
        end

        // R6: condition appears between polls, seen at edge 1+P
        idle_inputs();
        request(1'b1, 12'h210);
        @(negedge clk); @(negedge clk);
        satisfy(1'b1, 0, 7);
        @(negedge clk); chk("R6 no early done", 32'(done_o), 0);
        @(negedge clk); chk("R6 no early done", 32'(done_o), 0);
        @(negedge clk); chk("R6 done at poll", 32'(done_o), 1);
        chk("R6 err", 32'(err_o), 0);
        @(negedge clk);

        // R4 partial conditions, R9 ignored request while busy
        idle_inputs();
        request(1'b1, 12'h23c);
        ack_i = ~20'h8; pwr_sta_i = 32'h8; pwr_sta2_i = 32'h8;
        @(negedge clk);
        chk("R4 masked ack no done", 32'(done_o), 0);
        request(1'b0, 12'h2cc);
        chk("R9 cmd unchanged", 32'(cmd_o), 32'h8);
        ack_i = 20'h8; pwr_sta2_i = 32'h0;
        repeat (3) @(negedge clk);
        chk("R4 sta2 mismatch no done", 32'(done_o), 0);
        chk("R9 still busy", 32'(en_o), 1);
        pwr_sta2_i = 32'h8;
        repeat (4) @(negedge clk);
        chk("R4 done when all match", 32'(done_o), 1);
        chk("R4 err", 32'(err_o), 0);
        @(negedge clk);

        // R7 timeout
        idle_inputs();
        request(1'b0, 12'h29c);
        chk("R2 off cmd", 32'(cmd_o), 32'(20'(1) << 15));
        for (int k = 1; k <= 1 + M * P; k++) begin
            @(negedge clk);
            if (k == M * P) chk("R7 not yet", 32'(done_o), 0);
        end
        chk("R7 timeout done", 32'(done_o), 1);
        chk("R7 timeout err", 32'(err_o), 1);
        chk("R5 cmd clear on error", 32'(cmd_o), 0);
        chk("R3 en low on error", 32'(en_o), 0);
        repeat (3) @(negedge clk);
        chk("R10 err held", 32'(err_o), 1);
        chk("R10 done low", 32'(done_o), 0);
        request(1'b1, 12'h214);
        chk("R10 err cleared", 32'(err_o), 0);
        satisfy(1'b1, 8, 4);
        @(negedge clk);
        chk("R4 done dom8", 32'(done_o), 1);
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule